// File: doc/BRIEF.md
# Wiper Register Command Controller

This block is the command engine behind a single digitally controlled wiper. It sits after a two-wire slave front end, which handles bit timing, address matching and acknowledges, and hands over byte-level events: a START or repeated START, a STOP, a matched address with its read/write bit, each received byte, and each request for a byte to transmit. From these the block decodes an instruction byte and executes one of six commands. These commands read, write and transfer a 10-bit value between a volatile wiper register, four data registers that stand in for nonvolatile storage, and the host.

Data register writes are held back until the STOP that closes the command. They are refused when the write-protect input is low. An accepted write starts a busy window whose length is a parameter in system clocks, and while the window is open the block ignores new commands. The data registers keep their contents through reset, and reset copies data register 0 into the wiper register. The wiper register drives a 10-bit position output and a registered one-hot tap select with one bit per tap.

Top module: `wiper_cmd_ctrl`

## Requirements
- R1: During and after reset the wiper position equals the current content of data register 0, and data register contents survive reset (power-on defaults 155h, 2AAh, 000h, 3FFh for registers 0..3).
- R2: The instruction byte carries the opcode in bits [7:5] and the register select in bits [3:2]. Together with the address R/W bit the opcode picks the command: R/W=1 with 100 reads the wiper, with 101 reads a data register, with 110 loads the wiper from a data register. R/W=0 with 101 writes the wiper, with 110 writes a data register, with 111 saves the wiper into a data register.
- R3: A write-wiper command takes two data bytes: bits [1:0] of the first become position bits 9:8 (its upper six bits are ignored), and the second gives bits 7:0. The wiper changes on the cycle after the second byte is taken.
- R4: A read command answers the first byte request with {6'b0, value[9:8]} and the second with value[7:0]. Every further request in that command returns 00h. tx_valid pulses one cycle after tx_req.
- R5: A data register write or wiper save is committed on the STOP that closes a complete command when wr_protect_n is high, and busy then rises on the cycle after STOP.
- R6: With wr_protect_n low at STOP, neither a data register write nor a wiper save changes any register, and busy stays low.
- R7: A load command copies the selected data register into the wiper on the cycle after the instruction byte, without waiting for STOP. A save command copies the wiper into the selected data register.
- R8: A write or save cut off by STOP before its final byte, or by a repeated START before STOP, changes no register and raises no busy.
- R9: busy stays high for exactly BUSY_CYCLES cycles. While it is high, address, data and byte-request strobes are ignored, and the wiper does not change.
- R10: An opcode and R/W combination outside R2 is accepted but changes no register, raises no busy, and reads back 00h.
- R11: tap_sel has exactly one bit set, at the index equal to wiper_pos, one cycle after wiper_pos changes. Position 000h selects bit 0 and 3FFh selects the top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_protect_n | input | 1 | Low blocks data register writes |
| start_evt | input | 1 | START or repeated START seen (one-cycle pulse) |
| stop_evt | input | 1 | STOP seen (one-cycle pulse) |
| addr_valid | input | 1 | Matching address byte received (pulse) |
| addr_rd | input | 1 | R/W bit of that address byte |
| rx_valid | input | 1 | Byte received after the address (pulse) |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Front end needs a byte to send (pulse) |
| tx_valid | output | 1 | tx_byte is valid (pulse) |
| tx_byte | output | 8 | Byte to send |
| busy | output | 1 | Nonvolatile write window active |
| wiper_pos | output | 10 | Current wiper register |
| tap_sel | output | 1024 | One-hot tap select |

## Verification
The assertions take for granted that the front end raises at most one event strobe per cycle and that each is a single-cycle pulse. They also assume the front end issues no STOP-committed write while busy, since no address is accepted then. The busy-window and write-protect properties rely on STOP being the only commit trigger. The bench keeps within these assumptions by driving every strobe for exactly one clock from tasks on the falling edge, with a clock of idle between events. It issues commands during the busy window only to check that they are ignored.

// File: rtl/wiper_cmd_pkg.sv
package wiper_cmd_pkg;

  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_RD_WIPER   = 3'd1,
    OP_WR_WIPER   = 3'd2,
    OP_RD_REG     = 3'd3,
    OP_WR_REG     = 3'd4,
    OP_LOAD_WIPER = 3'd5,
    OP_SAVE_WIPER = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_INSTR = 3'd1,
    S_HI    = 3'd2,
    S_LO    = 3'd3,
    S_DONE  = 3'd4
  } seq_e;

  // opcode field values, bits [7:5] of the instruction byte
  localparam logic [2:0] OPC_100 = 3'b100;
  localparam logic [2:0] OPC_101 = 3'b101;
  localparam logic [2:0] OPC_110 = 3'b110;
  localparam logic [2:0] OPC_111 = 3'b111;

endpackage

// File: rtl/wcc_decode.sv
module wcc_decode
  import wiper_cmd_pkg::*;
(
  input  logic       rw_i,
  input  logic [7:0] instr_i,
  output op_e        op_o,
  output logic [1:0] sel_o
);

  logic [2:0] opc;
  assign opc   = instr_i[7:5];
  assign sel_o = instr_i[3:2];

  // R2: command chosen by R/W bit together with the opcode field
  always_comb begin
    op_o = OP_NONE;
    if (rw_i) begin
      case (opc)
        OPC_100: op_o = OP_RD_WIPER;
        OPC_101: op_o = OP_RD_REG;
        OPC_110: op_o = OP_LOAD_WIPER;
        default: op_o = OP_NONE;
      endcase
    end else begin
      case (opc)
        OPC_101: op_o = OP_WR_WIPER;
        OPC_110: op_o = OP_WR_REG;
        OPC_111: op_o = OP_SAVE_WIPER;
        default: op_o = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/wcc_store.sv
module wcc_store #(
  parameter int POS_W = 10,
  parameter int NREG  = 4,
  parameter logic [NREG*POS_W-1:0] INIT = '0,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [SEL_W-1:0] waddr_i,
  input  logic [POS_W-1:0] wdata_i,
  input  logic [SEL_W-1:0] raddr_i,
  output logic [POS_W-1:0] rdata_o,
  output logic [POS_W-1:0] home_o
);

  // no reset on the array: contents stand in for retained storage
  logic [POS_W-1:0] mem [NREG];

  initial begin
    for (int i = 0; i < NREG; i++) mem[i] = INIT[i*POS_W +: POS_W];
  end

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
  assign home_o  = mem[0];

endmodule

// File: rtl/wcc_busy_timer.sv
module wcc_busy_timer #(
  parameter int CYCLES = 500,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= CNT_W'(CYCLES - 1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;

  // R9: a new window is never requested while one is open
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_q);

  // R9: the window closes only once the count is spent
  a_r9_close_at_zero: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(cnt_q) == '0);

endmodule

// File: rtl/wcc_tap_decode.sv
module wcc_tap_decode #(
  parameter int POS_W = 10,
  localparam int TAPS = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] pos_i,
  output logic [TAPS-1:0]  tap_o
);

  logic [TAPS-1:0] tap_q;

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    localparam logic [POS_W-1:0] IDX = POS_W'(g);
    always_ff @(posedge clk) tap_q[g] <= (pos_i == IDX);
  end

  assign tap_o = tap_q;

  // R11: exactly one tap closed, at the previous cycle's position
  a_r11_one_tap: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $countones(tap_q) == 1);

  a_r11_tap_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> tap_q[$past(pos_i)]);

endmodule

// File: rtl/wiper_cmd_ctrl.sv
module wiper_cmd_ctrl
  import wiper_cmd_pkg::*;
#(
  parameter int POS_W       = 10,
  parameter int BUSY_CYCLES = 500,
  parameter logic [4*POS_W-1:0] INIT_REGS = {10'h3FF, 10'h000, 10'h2AA, 10'h155},
  localparam int NREG  = 4,
  localparam int SEL_W = 2,
  localparam int HI_W  = POS_W - 8,
  localparam int TAPS  = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_protect_n,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             addr_valid,
  input  logic             addr_rd,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             tx_req,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  output logic             busy,
  output logic [POS_W-1:0] wiper_pos,
  output logic [TAPS-1:0]  tap_sel
);

  seq_e             state_q;
  logic             rw_q;
  op_e              op_q;
  logic [HI_W-1:0]  hi_q;
  logic [POS_W-1:0] wiper_q;
  logic [POS_W-1:0] rd_val_q;
  logic             pend_q;
  logic [SEL_W-1:0] pend_sel_q;
  logic [POS_W-1:0] pend_val_q;
  logic             tx_valid_q;
  logic [7:0]       tx_byte_q;

  op_e              dec_op;
  logic [SEL_W-1:0] dec_sel;
  logic [POS_W-1:0] reg_rdata;
  logic [POS_W-1:0] reg_home;
  logic             commit;
  logic             is_wr;
  logic             is_rd;

  wcc_decode u_dec (
    .rw_i    (rw_q),
    .instr_i (rx_byte),
    .op_o    (dec_op),
    .sel_o   (dec_sel)
  );

  wcc_store #(.POS_W(POS_W), .NREG(NREG), .INIT(INIT_REGS)) u_store (
    .clk     (clk),
    .we_i    (commit),
    .waddr_i (pend_sel_q),
    .wdata_i (pend_val_q),
    .raddr_i (dec_sel),
    .rdata_o (reg_rdata),
    .home_o  (reg_home)
  );

  wcc_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk     (clk),
    .rst     (rst),
    .start_i (commit),
    .busy_o  (busy)
  );

  wcc_tap_decode #(.POS_W(POS_W)) u_tap (
    .clk   (clk),
    .rst   (rst),
    .pos_i (wiper_q),
    .tap_o (tap_sel)
  );

  // R5/R6: deferred nonvolatile write lands only on STOP with protect released
  assign commit = stop_evt && !start_evt && pend_q && wr_protect_n && !busy && !rst;
  assign is_wr  = (op_q == OP_WR_WIPER) || (op_q == OP_WR_REG);
  assign is_rd  = (op_q == OP_RD_WIPER) || (op_q == OP_RD_REG);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      rw_q       <= 1'b0;
      op_q       <= OP_NONE;
      hi_q       <= '0;
      wiper_q    <= reg_home;  // R1: recall register 0
      rd_val_q   <= '0;
      pend_q     <= 1'b0;
      pend_sel_q <= '0;
      pend_val_q <= '0;
      tx_valid_q <= 1'b0;
      tx_byte_q  <= '0;
    end else begin
      tx_valid_q <= 1'b0;
      if (start_evt || stop_evt) begin
        // R8: any framing event drops an unfinished command
        state_q <= S_IDLE;
        pend_q  <= 1'b0;
      end else if (!busy) begin
        if (addr_valid) begin
          rw_q    <= addr_rd;
          state_q <= S_INSTR;
          pend_q  <= 1'b0;
        end else if (rx_valid) begin
          case (state_q)
            S_INSTR: begin
              op_q     <= dec_op;
              rd_val_q <= (dec_op == OP_RD_WIPER) ? wiper_q : reg_rdata;
              case (dec_op)
                OP_LOAD_WIPER: begin
                  wiper_q <= reg_rdata;  // R7
                  state_q <= S_DONE;
                end
                OP_SAVE_WIPER: begin
                  pend_q     <= 1'b1;
                  pend_sel_q <= dec_sel;
                  pend_val_q <= wiper_q;
                  state_q    <= S_DONE;
                end
                OP_WR_WIPER, OP_WR_REG: begin
                  pend_sel_q <= dec_sel;
                  state_q    <= S_HI;
                end
                OP_RD_WIPER, OP_RD_REG: state_q <= S_HI;
                default:                state_q <= S_DONE;  // R10
              endcase
            end
            S_HI: begin
              if (is_wr) begin
                hi_q    <= rx_byte[HI_W-1:0];
                state_q <= S_LO;
              end
            end
            S_LO: begin
              if (is_wr) begin
                if (op_q == OP_WR_WIPER) begin
                  wiper_q <= {hi_q, rx_byte};  // R3
                end else begin
                  pend_q     <= 1'b1;
                  pend_val_q <= {hi_q, rx_byte};
                end
                state_q <= S_DONE;
              end
            end
            default: ;
          endcase
        end else if (tx_req) begin
          tx_valid_q <= 1'b1;
          tx_byte_q  <= 8'h00;
          if (is_rd && state_q == S_HI) begin
            tx_byte_q <= {{(8-HI_W){1'b0}}, rd_val_q[POS_W-1:8]};  // R4
            state_q   <= S_LO;
          end else if (is_rd && state_q == S_LO) begin
            tx_byte_q <= rd_val_q[7:0];
            state_q   <= S_DONE;
          end
        end
      end
    end
  end

  assign tx_valid  = tx_valid_q;
  assign tx_byte   = tx_byte_q;
  assign wiper_pos = wiper_q;

  // R5: busy only opens right after a STOP
  a_r5_busy_after_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_evt));

  // R6: protected STOP never opens a busy window
  a_r6_protect_no_busy: assert property (@(posedge clk) disable iff (rst)
    (stop_evt && !wr_protect_n && !busy) |=> !busy);

  // R8: a repeated START never opens a busy window
  a_r8_start_no_busy: assert property (@(posedge clk) disable iff (rst)
    (start_evt && !busy) |=> !busy);

  // R9: wiper frozen while busy
  a_r9_busy_freeze: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(wiper_q));

  // R4: a transmit byte only answers a request
  a_r4_tx_answers_req: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(tx_req));

endmodule

// File: tb/wiper_cmd_ctrl_bench.sv
module wiper_cmd_ctrl_bench;

  localparam int BUSY = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_protect_n = 1'b1;
  logic        start_evt = 1'b0, stop_evt = 1'b0;
  logic        addr_valid = 1'b0, addr_rd = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        tx_req = 1'b0;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        busy;
  logic [9:0]  wiper_pos;
  logic [1023:0] tap_sel;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  wiper_cmd_ctrl #(.BUSY_CYCLES(BUSY)) u_wiper_cmd_ctrl (
    .clk(clk), .rst(rst), .wr_protect_n(wr_protect_n),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .addr_valid(addr_valid), .addr_rd(addr_rd),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .busy(busy), .wiper_pos(wiper_pos), .tap_sel(tap_sel)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected transmit bytes
  always @(negedge clk) begin
    if (!rst && tx_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected byte act=%0h exp=none", tx_byte);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (tx_byte !== e) begin
          errors++;
          $display("FAIL %s tx act=%0h exp=%0h", t, tx_byte, e);
        end
      end
    end
  end

  task automatic expect_tx(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  task automatic do_start();
    @(negedge clk); start_evt = 1'b1; @(negedge clk); start_evt = 1'b0;
  endtask
  task automatic do_stop();
    @(negedge clk); stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;
  endtask
  task automatic do_addr(input logic rd);
    @(negedge clk); addr_rd = rd; addr_valid = 1'b1; @(negedge clk); addr_valid = 1'b0;
  endtask
  task automatic do_byte(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_valid = 1'b1; @(negedge clk); rx_valid = 1'b0;
  endtask
  task automatic do_ask();
    @(negedge clk); tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
  endtask

  function automatic logic [7:0] ins(input logic [2:0] opc, input logic [1:0] sel);
    return {opc, 1'b0, sel, 2'b00};
  endfunction

  // start, address, instruction, then n data bytes (no STOP)
  task automatic cmd_head(input logic rw, input logic [2:0] opc, input logic [1:0] sel,
                          input logic [7:0] b0, input logic [7:0] b1, input int n);
    do_start();
    do_addr(rw);
    do_byte(ins(opc, sel));
    if (n > 0) do_byte(b0);
    if (n > 1) do_byte(b1);
  endtask

  task automatic cmd_read(input logic [2:0] opc, input logic [1:0] sel,
                          input logic [9:0] v, input int asks, input string tag);
    expect_tx({6'b0, v[9:8]}, tag);
    expect_tx(v[7:0], tag);
    for (int i = 2; i < asks; i++) expect_tx(8'h00, tag);
    cmd_head(1'b1, opc, sel, 8'h00, 8'h00, 0);
    for (int i = 0; i < asks; i++) do_ask();
    do_stop();
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_tap(input int pos, input string tag);
    @(negedge clk);
    check(tag, tap_sel[pos], 1);
    check(tag, $countones(tap_sel), 1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: recall of register 0 default
    check("R1 reset wiper", wiper_pos, 10'h155);
    check("R1 reset busy", busy, 0);
    check_tap(10'h155, "R11 reset tap");

    // R2/R4 reads
    cmd_read(3'b100, 2'd0, 10'h155, 2, "R4 read wiper");
    cmd_read(3'b101, 2'd1, 10'h2AA, 3, "R4 read reg1 with extra 00");

    // R3 write wiper, upper six bits of first byte ignored
    cmd_head(1'b0, 3'b101, 2'd0, 8'hFF, 8'hFF, 2);
    check("R3 write wiper 3FF", wiper_pos, 10'h3FF);
    check_tap(1023, "R11 top tap");
    do_stop();
    check("R3 wiper write no busy", busy, 0);
    cmd_head(1'b0, 3'b101, 2'd0, 8'h02, 8'h5A, 1);
    check("R3 wiper unchanged after first byte", wiper_pos, 10'h3FF);
    do_byte(8'h5A);
    check("R3 write wiper 25A", wiper_pos, 10'h25A);
    do_stop();
    cmd_read(3'b100, 2'd0, 10'h25A, 2, "R4 read back wiper");
    cmd_head(1'b0, 3'b101, 2'd0, 8'h00, 8'h00, 2);
    do_stop();
    check("R3 write wiper 0", wiper_pos, 10'h000);
    check_tap(0, "R11 bottom tap");

    // R5 write reg2, busy window length R9
    cmd_head(1'b0, 3'b110, 2'd2, 8'h01, 8'hC3, 2);
    check("R5 no busy before stop", busy, 0);
    do_stop();
    check("R5 busy after stop", busy, 1);
    repeat (BUSY - 1) @(negedge clk);
    check("R9 busy last cycle", busy, 1);
    @(negedge clk);
    check("R9 busy ends", busy, 0);
    cmd_read(3'b101, 2'd2, 10'h1C3, 2, "R5 read reg2");

    // R9 commands ignored during busy
    cmd_head(1'b0, 3'b110, 2'd3, 8'h00, 8'hF0, 2);
    do_stop();
    cmd_head(1'b0, 3'b101, 2'd0, 8'h01, 8'h11, 2);
    do_stop();
    check("R9 wiper ignored while busy", wiper_pos, 10'h000);
    check("R9 still busy", busy, 1);
    wait_idle();
    cmd_read(3'b101, 2'd3, 10'h0F0, 2, "R5 read reg3");

    // R6 write protect
    wr_protect_n = 1'b0;
    cmd_head(1'b0, 3'b110, 2'd1, 8'h00, 8'h01, 2);
    do_stop();
    check("R6 protected write no busy", busy, 0);
    cmd_head(1'b0, 3'b111, 2'd1, 8'h00, 8'h00, 0);
    do_stop();
    check("R6 protected save no busy", busy, 0);
    cmd_read(3'b101, 2'd1, 10'h2AA, 2, "R6 reg1 unchanged");
    wr_protect_n = 1'b1;

    // R7 load and save
    cmd_head(1'b1, 3'b110, 2'd2, 8'h00, 8'h00, 0);
    check("R7 load before stop", wiper_pos, 10'h1C3);
    do_stop();
    cmd_head(1'b0, 3'b101, 2'd0, 8'h02, 8'hE7, 2);
    do_stop();
    cmd_head(1'b0, 3'b111, 2'd0, 8'h00, 8'h00, 0);
    do_stop();
    check("R7 save busy", busy, 1);
    wait_idle();
    cmd_read(3'b101, 2'd0, 10'h2E7, 2, "R7 saved reg0");

    // R1 persistence through reset
    do_reset();
    check("R1 recall saved reg0", wiper_pos, 10'h2E7);

    // R8 aborts
    cmd_head(1'b0, 3'b110, 2'd1, 8'h03, 8'h00, 1);
    do_stop();
    check("R8 short write no busy", busy, 0);
    cmd_head(1'b0, 3'b110, 2'd1, 8'h03, 8'h33, 2);
    do_start();
    check("R8 restart no busy", busy, 0);
    do_stop();
    check("R8 stop after restart no busy", busy, 0);
    cmd_read(3'b101, 2'd1, 10'h2AA, 2, "R8 reg1 unchanged");
    cmd_head(1'b0, 3'b101, 2'd0, 8'h01, 8'h00, 1);
    do_stop();
    check("R8 short wiper write", wiper_pos, 10'h2E7);

    // R10 unsupported combinations
    cmd_head(1'b0, 3'b000, 2'd0, 8'h03, 8'hFF, 2);
    do_stop();
    check("R10 op000 wiper", wiper_pos, 10'h2E7);
    check("R10 op000 busy", busy, 0);
    cmd_head(1'b0, 3'b100, 2'd0, 8'h00, 8'h12, 2);
    do_stop();
    check("R10 write-side 100 busy", busy, 0);
    check("R10 write-side 100 wiper", wiper_pos, 10'h2E7);
    expect_tx(8'h00, "R10 read 111");
    expect_tx(8'h00, "R10 read 111");
    cmd_head(1'b1, 3'b111, 2'd0, 8'h00, 8'h00, 0);
    do_ask();
    do_ask();
    do_stop();
    cmd_read(3'b101, 2'd0, 10'h2E7, 2, "R10 reg0 unchanged");

    repeat (3) @(negedge clk);
    check("R4 scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule